// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt lines and turns them into two active-low requests for a processor: a normal request and a fast request. Each line has a mode register and a vector register. The mode register holds a 3-bit priority and a 2-bit trigger type. The vector register holds the handler address that the controller returns for that line. Line 0 is the fast line. It drives only the fast request and never takes part in priority selection. Lines 1 to 31 compete for the normal request.

Software takes a normal interrupt by reading the vector register. The controller returns the vector of the best enabled pending line. In the same cycle it records that line's priority as the current service level on a small in-service stack. While that level is in service, only a strictly higher priority can raise the normal request again. A write to the end-of-interrupt register drops the most recent level, which lets lower priorities through again.

The register port is a plain one-cycle strobe interface with no back-pressure. Read data is valid in the same cycle as `rd_en`. Every access completes in one cycle. Reads of the two vector registers have side effects, and those take effect at the clock edge that ends the read cycle.

Top module: `vprio_intc`

## Requirements
- R1: After reset, `irq_n` and `fiq_n` are 1, the enable mask reads 0, and every mode and vector register reads 0.
- R2: The mode register of line i sits at byte offset 4*i and reads back with priority in bits [2:0] and trigger in bits [6:5]. The vector register of line i sits at 0x080+4*i. The enable mask reads back at 0x120.
- R3: Trigger encodings are 00 for level active-high, 01 for level active-low, 10 for rising edge and 11 for falling edge.
- R4: An edge line latches a pending flag that is cleared when its vector is returned by a read. A level line stays pending for as long as its input is at the active level, including after its vector has been read.
- R5: Writing 1s to 0x120 sets enable bits, and writing 1s to 0x124 clears them. A disabled line never pulls `irq_n` or `fiq_n` low.
- R6: Among the enabled pending lines 1..31, the highest priority wins (7 is highest). On equal priority the lowest line number wins.
- R7: A read at 0x100 returns the winner's vector and pushes the winner's priority onto the in-service stack. `irq_n` is low only when a winner exists and either the stack is empty or the winner's priority is strictly greater than the level on top of the stack.
- R8: A write at 0x130 pops one level from the stack. With an empty stack it has no effect.
- R9: A read at 0x100 while `irq_n` is high returns the spurious value 0xFFFF0000 and changes no state.
- R10: Line 0 drives only `fiq_n`. A read at 0x104 returns line 0's vector and clears its edge latch while `fiq_n` is low; otherwise the read returns the spurious value.
- R11: The stack holds 8 levels, so 8 strictly increasing priorities can nest and then unwind one per end-of-interrupt write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Raw interrupt lines; line 0 is the fast line |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 9 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| irq_n | output | 1 | Active-low normal interrupt request |
| fiq_n | output | 1 | Active-low fast interrupt request |

## Verification
The bench sweeps eight priority and enable patterns over all 31 normal lines with every input raised. Since 31 lines share 8 levels, ties always occur. A design with reversed tie order or a non-strict comparison returns the wrong vector. Nesting checks cover several cases: an equal-priority arrival must stay silent, a read with no qualifying line must return the spurious value without pushing, and eight levels must nest fully and then unwind. A stack that pushed on a spurious read or went below empty would leave `irq_n` stuck high. Each trigger type is exercised by itself. A level line that was wrongly cleared by its vector read would not re-raise `irq_n` after end-of-interrupt. An edge line that was not cleared would keep `irq_n` low.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int PRIO_W = 3;

  typedef enum logic [1:0] {
    TRIG_LVL_HI = 2'b00,
    TRIG_LVL_LO = 2'b01,
    TRIG_RISE   = 2'b10,
    TRIG_FALL   = 2'b11
  } trig_e;

  localparam logic [8:0] OFS_IVR  = 9'h100;
  localparam logic [8:0] OFS_FVR  = 9'h104;
  localparam logic [8:0] OFS_IEN  = 9'h120;
  localparam logic [8:0] OFS_IDIS = 9'h124;
  localparam logic [8:0] OFS_EOI  = 9'h130;
endpackage

// File: rtl/irq_src_detect.sv
module irq_src_detect (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw,
  input  logic [1:0] trig,
  input  logic       clr,
  output logic       pending
);
  logic prev_q, edge_q, edge_hit;

  // trig[1] selects edge mode, trig[0] inverts the active sense
  always_comb edge_hit = trig[1] & (trig[0] ? (prev_q & ~raw) : (raw & ~prev_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      prev_q <= raw;
      if (edge_hit)  edge_q <= 1'b1;
      else if (clr)  edge_q <= 1'b0;
    end
  end

  assign pending = trig[1] ? edge_q : (raw ^ trig[0]);

  // R4
  edge_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_hit) |=> !edge_q);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import prio_irq_pkg::*;
#(
  parameter int N = 32,
  localparam int IDW = $clog2(N)
) (
  input  logic [N-1:0]             cand,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output logic                     win_valid,
  output logic [IDW-1:0]           win_id,
  output logic [PRIO_W-1:0]        win_prio
);
  // descending scan with >= keeps the lowest index among equals
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i] && (!win_valid || prio[i] >= win_prio)) begin
        win_valid = 1'b1;
        win_id    = IDW'(i);
        win_prio  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
  import prio_irq_pkg::*;
#(
  parameter int DEPTH = 2 ** PRIO_W,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_lvl,
  input  logic              pop,
  output logic              busy,
  output logic [PRIO_W-1:0] top_lvl
);
  logic [PRIO_W-1:0] lvl_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [IX_W-1:0]   top_ix;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (push)                   cnt_q <= cnt_q + CNT_W'(1);
    else if (pop && cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (push) lvl_q[cnt_q[IX_W-1:0]] <= push_lvl;
  end

  assign top_ix  = IX_W'(cnt_q - CNT_W'(1));
  assign busy    = (cnt_q != '0);
  assign top_lvl = lvl_q[top_ix];

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CNT_W'(DEPTH)));
  // R7
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (busy && top_lvl == $past(push_lvl)));
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !busy) |=> !busy);
endmodule

// File: rtl/vprio_intc.sv
module vprio_intc
  import prio_irq_pkg::*;
#(
  parameter int          NUM_SRC      = 32,
  parameter logic [31:0] SPURIOUS_VEC = 32'hFFFF_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [8:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               irq_n,
  output logic               fiq_n
);
  localparam int IDW = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0][1:0]        trig_q;
  logic [31:0]                    vec_q [NUM_SRC];
  logic [NUM_SRC-1:0]             en_q, pend, cand, clr;

  logic [1:0]        region;
  logic [IDW-1:0]    sel;
  logic              sel_ok, smr_wr, svr_wr, ivr_rd, fvr_rd, eoi_wr;
  logic              win_valid, busy, irq_req, fiq_act;
  logic [IDW-1:0]    win_id;
  logic [PRIO_W-1:0] win_prio, top_lvl;

  // ---- address decode ----
  assign region = addr[8:7];
  assign sel    = addr[2 +: IDW];
  assign sel_ok = (addr[1:0] == 2'b00) && (int'(addr[6:2]) < NUM_SRC);
  assign smr_wr = wr_en && region == 2'b00 && sel_ok;
  assign svr_wr = wr_en && region == 2'b01 && sel_ok;
  assign ivr_rd = rd_en && addr == OFS_IVR;
  assign fvr_rd = rd_en && addr == OFS_FVR;
  assign eoi_wr = wr_en && addr == OFS_EOI;

  // ---- configuration registers ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      trig_q <= '0;
      en_q   <= '0;
      for (int i = 0; i < NUM_SRC; i++) vec_q[i] <= '0;
    end else begin
      if (smr_wr) begin
        prio_q[sel] <= wdata[PRIO_W-1:0];
        trig_q[sel] <= wdata[6:5];
      end
      if (svr_wr) vec_q[sel] <= wdata;
      if (wr_en && addr == OFS_IEN)       en_q <= en_q | wdata[NUM_SRC-1:0];
      else if (wr_en && addr == OFS_IDIS) en_q <= en_q & ~wdata[NUM_SRC-1:0];
    end
  end

  // ---- per-line pending detection ----
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
    irq_src_detect u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (src_in[g]),
      .trig    (trig_q[g]),
      .clr     (clr[g]),
      .pending (pend[g])
    );
  end

  assign cand    = pend & en_q;
  assign fiq_act = cand[0];

  // ---- priority selection over lines 1..N-1 ----
  irq_prio_arb #(.N(NUM_SRC)) u_arb (
    .cand      ({cand[NUM_SRC-1:1], 1'b0}),
    .prio      (prio_q),
    .win_valid (win_valid),
    .win_id    (win_id),
    .win_prio  (win_prio)
  );

  irq_svc_stack u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ivr_rd && irq_req),
    .push_lvl (win_prio),
    .pop      (eoi_wr),
    .busy     (busy),
    .top_lvl  (top_lvl)
  );

  assign irq_req = win_valid && (!busy || win_prio > top_lvl);
  assign irq_n   = ~irq_req;
  assign fiq_n   = ~fiq_act;

  always_comb begin
    clr = '0;
    if (ivr_rd && irq_req) clr[win_id] = 1'b1;
    if (fvr_rd && fiq_act) clr[0]      = 1'b1;
  end

  // ---- read mux ----
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (region == 2'b00 && sel_ok) begin
        rdata[PRIO_W-1:0] = prio_q[sel];
        rdata[6:5]        = trig_q[sel];
      end else if (region == 2'b01 && sel_ok) begin
        rdata = vec_q[sel];
      end else if (addr == OFS_IVR) begin
        rdata = irq_req ? vec_q[win_id] : SPURIOUS_VEC;
      end else if (addr == OFS_FVR) begin
        rdata = fiq_act ? vec_q[0] : SPURIOUS_VEC;
      end else if (addr == OFS_IEN) begin
        rdata[NUM_SRC-1:0] = en_q;
      end
    end
  end

  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (|cand[NUM_SRC-1:1]));
endmodule

// File: tb/vprio_intc_bench.sv
`timescale 1ns/1ps
module vprio_intc_bench;
  localparam logic [31:0] SPUR = 32'hFFFF_0000;
  localparam logic [8:0] A_IVR = 9'h100, A_FVR = 9'h104, A_IEN = 9'h120,
                         A_IDIS = 9'h124, A_EOI = 9'h130;
  localparam logic [1:0] LHI = 2'b00, LLO = 2'b01, RISE = 2'b10, FALL = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n, fiq_n;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] d;

  always #2 clk = ~clk;

  vprio_intc u_vprio_intc (
    .clk(clk), .rst_n(rst_n), .src_in(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .fiq_n(fiq_n));

  function automatic logic [31:0] vec(input int i);
    return 32'h4000_0000 + 32'(i) * 32'h100;
  endfunction

  function automatic int pr(input int i, input int p);
    return (i * (2 * p + 3) + p) % 8;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] v);
    @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; #1;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0; #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
  endtask

  task automatic prog(input int i, input logic [1:0] t, input int p);
    wr(9'(4 * i), {25'b0, t, 2'b00, 3'(p)});
    wr(9'(9'h80 + 4 * i), vec(i));
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk); src[i] = v; #1;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); src[i] = 1'b1;
    @(negedge clk); src[i] = 1'b0; #1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    do_reset();
    // R1 reset state
    chk("R1 irq_n", 32'(irq_n), 1);
    chk("R1 fiq_n", 32'(fiq_n), 1);
    rd(A_IEN, d); chk("R1 enable mask", d, 0);
    rd(9'h014, d); chk("R1 mode reg", d, 0);
    rd(9'h0FC, d); chk("R1 vector reg", d, 0);
    rd(A_IVR, d);  chk("R9 spurious after reset", d, SPUR);

    // R2 register readback over every line
    for (int i = 0; i < 32; i++) prog(i, 2'(i % 4), (i * 3) % 8);
    for (int i = 0; i < 32; i++) begin
      rd(9'(4 * i), d);
      chk("R2 mode readback", d, {25'b0, 2'(i % 4), 2'b00, 3'((i * 3) % 8)});
      rd(9'(9'h80 + 4 * i), d);
      chk("R2 vector readback", d, vec(i));
    end

    // R4 single edge line sweep
    do_reset();
    for (int i = 1; i < 32; i++) begin
      prog(i, RISE, i % 8);
      wr(A_IEN, 32'(1) << i);
      pulse(i);
      chk("R4 edge raises irq", 32'(irq_n), 0);
      rd(A_IVR, d); chk("R7 edge vector", d, vec(i));
      chk("R4 edge cleared by read", 32'(irq_n), 1);
      wr(A_EOI, 0);
      chk("R8 stays quiet after eoi", 32'(irq_n), 1);
      wr(A_IDIS, 32'(1) << i);
    end

    // R6 arbitration sweep with ties
    for (int p = 0; p < 8; p++) begin
      logic [31:0] m;
      int w;
      do_reset();
      m = (32'hB4E1_6C3D ^ (32'h1111_1111 * 32'(p))) & 32'hFFFF_FFFE;
      for (int i = 1; i < 32; i++) prog(i, LHI, pr(i, p));
      wr(A_IEN, m);
      w = 0;
      for (int i = 1; i < 32; i++)
        if (m[i] && (w == 0 || pr(i, p) > pr(w, p))) w = i;
      @(negedge clk); src = 32'hFFFF_FFFE; #1;
      chk("R6 irq asserted", 32'(irq_n), 0);
      rd(A_IVR, d); chk("R6 winner vector", d, vec(w));
      chk("R7 no equal-level reassert", 32'(irq_n), 1);
      rd(A_IVR, d); chk("R9 spurious while in service", d, SPUR);
      wr(A_EOI, 0);
      chk("R4 level stays pending", 32'(irq_n), 0);
      rd(A_IVR, d); chk("R6 winner again", d, vec(w));
      wr(A_EOI, 0);
      @(negedge clk); src = '0; #1;
      chk("R4 level gone", 32'(irq_n), 1);
    end

    // R7 nesting
    do_reset();
    wr(A_EOI, 0);   // R8 pop on empty stack
    prog(4, LHI, 2); prog(9, LHI, 5); prog(12, LHI, 5); prog(20, LHI, 7);
    wr(A_IEN, (32'(1) << 4) | (32'(1) << 9) | (32'(1) << 12) | (32'(1) << 20));
    set_src(4, 1);  chk("R8 empty eoi harmless", 32'(irq_n), 0);
    rd(A_IVR, d);   chk("R7 nest vec4", d, vec(4));
    set_src(9, 1);  chk("R7 higher preempts", 32'(irq_n), 0);
    rd(A_IVR, d);   chk("R7 nest vec9", d, vec(9));
    set_src(12, 1); chk("R7 equal held off", 32'(irq_n), 1);
    set_src(20, 1); chk("R7 top preempts", 32'(irq_n), 0);
    rd(A_IVR, d);   chk("R7 nest vec20", d, vec(20));
    set_src(20, 0);
    wr(A_EOI, 0);   chk("R8 pop to level 5", 32'(irq_n), 1);
    wr(A_EOI, 0);   chk("R8 pop to level 2", 32'(irq_n), 0);
    rd(A_IVR, d);   chk("R6 tie lowest index", d, vec(9));

    // R11 full depth
    do_reset();
    for (int k = 1; k <= 8; k++) prog(k, LHI, k - 1);
    wr(A_IEN, 32'h0000_01FE);
    for (int k = 1; k <= 8; k++) begin
      set_src(k, 1);
      chk("R11 level raises", 32'(irq_n), 0);
      rd(A_IVR, d); chk("R11 nested vector", d, vec(k));
    end
    chk("R11 full stack quiet", 32'(irq_n), 1);
    for (int k = 8; k >= 1; k--) begin
      set_src(k, 0);
      wr(A_EOI, 0);
      chk("R11 unwind", 32'(irq_n), 1);
    end
    set_src(1, 1); chk("R11 stack empty again", 32'(irq_n), 0);

    // R3 active-low level and falling edge
    do_reset();
    prog(3, LLO, 1); wr(A_IEN, 32'(1) << 3);
    chk("R3 level low active", 32'(irq_n), 0);
    rd(A_IVR, d); chk("R3 level low vector", d, vec(3));
    set_src(3, 1); wr(A_EOI, 0);
    chk("R3 level low released", 32'(irq_n), 1);
    prog(5, FALL, 4); wr(A_IEN, 32'(1) << 5);
    set_src(5, 1); chk("R3 rise ignored in fall mode", 32'(irq_n), 1);
    set_src(5, 0); @(negedge clk); #1;
    chk("R3 falling edge latched", 32'(irq_n), 0);
    rd(A_IVR, d); chk("R3 fall vector", d, vec(5));
    chk("R4 fall latch cleared", 32'(irq_n), 1);

    // R5 enable / disable
    do_reset();
    prog(7, LHI, 3); set_src(7, 1);
    chk("R5 disabled line silent", 32'(irq_n), 1);
    wr(A_IEN, 32'(1) << 7); chk("R5 enable raises", 32'(irq_n), 0);
    wr(A_IDIS, 32'(1) << 7); chk("R5 disable drops", 32'(irq_n), 1);
    rd(A_IEN, d); chk("R5 mask cleared", d, 0);

    // R10 fast line
    do_reset();
    prog(0, RISE, 7); wr(A_IEN, 32'h1);
    pulse(0);
    chk("R10 fiq low", 32'(fiq_n), 0);
    chk("R10 irq untouched", 32'(irq_n), 1);
    rd(A_FVR, d); chk("R10 fast vector", d, vec(0));
    chk("R10 fiq cleared", 32'(fiq_n), 1);
    rd(A_FVR, d); chk("R10 fast spurious", d, SPUR);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule